// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block sits between a CAN protocol engine and a host. Each time the engine finishes a frame it presents the identifier, the frame-format flag, the length code and up to eight data bytes in a single cycle. The block decides whether the current mode accepts that frame. It then packs the frame into one entry of a shared byte store. The entry is a short header followed by the data bytes.

The host always sees the oldest stored entry through a small read window. A byte offset selects the byte and the block returns it combinationally. After reading the entry, the host issues a release command. The block then skips past that entry and frees its bytes for new frames.

Space is counted in bytes, not in frames. Many short frames fit where only a few long ones would. A frame that does not fit in the remaining space is discarded in full and raises a sticky overrun flag.

Top module: `canrx_msg_fifo`

## Requirements
- R1: An entry begins with a header. Header byte 0 is {format flag, 3'b000, length code as received}. For a standard frame, byte 1 is identifier bits 10:3 and byte 2 is {identifier bits 2:0, 5'b00000}. For an extended frame, bytes 1 to 4 carry identifier bits 28:21, 20:13 and 12:5, then {identifier bits 4:0, 3'b000}.
- R2: The store holds 64 bytes in total, shared by all entries. A frame is stored only if its entry length is no larger than the free byte count. Any number of entries may be held at once.
- R3: Data bytes follow the header in order, data byte j being bits 8j+7:8j of the data input. A length code above 8 stores 8 data bytes, so an entry takes 3 or 5 bytes plus min(length code, 8).
- R4: With the extended-mode input high, both standard and extended frames are stored.
- R5: With the extended-mode input low (basic mode), an extended frame is not stored and raises no receive pulse and no overrun. Standard frames are stored as usual.
- R6: A frame that does not fit sets the overrun flag. None of its bytes are stored, no receive pulse is raised, and the entries already held are left unchanged.
- R7: The receive-buffer-status output is high whenever at least one entry is held and low otherwise.
- R8: A release command moves the read window to the next entry and frees the bytes of the old one. A release while the store is empty has no effect.
- R9: A clear-overrun command lowers the overrun flag on the next clock edge. A new overrun in the same cycle wins over the clear.
- R10: While the reset-mode input is high, the store is emptied, the overrun flag is cleared, and incoming frames are ignored. Storage restarts at the beginning afterwards.
- R11: The receive output is a one-cycle pulse in the cycle after each frame is stored, and it stays low for every frame that is not stored.
- R12: Storage wraps around the end of the byte array. An entry that straddles the boundary reads back correctly through the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode_i | input | 1 | Controller reset mode: empties the store |
| ext_mode_i | input | 1 | 1 = extended mode, 0 = basic mode |
| frm_valid_i | input | 1 | One-cycle strobe: completed frame present |
| frm_ext_i | input | 1 | Frame uses a 29-bit identifier |
| frm_id_i | input | 29 | Identifier, right-aligned |
| frm_dlc_i | input | 4 | Length code |
| frm_data_i | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rd_addr_i | input | 4 | Byte offset inside the oldest entry |
| rd_data_o | output | 8 | Byte at that offset |
| release_i | input | 1 | Release the oldest entry |
| clr_overrun_i | input | 1 | Clear the overrun flag |
| rbs_o | output | 1 | At least one entry held |
| overrun_o | output | 1 | Sticky overrun flag |
| rx_irq_o | output | 1 | Receive pulse |

## Verification
The bench fills the store to exactly 64 bytes. A design that compared against the free count with the wrong inequality would reject that last frame or accept the 65th byte. It then drains the store, and later stores 13-byte entries until one straddles the array end. A design with a pointer that did not wrap modulo the depth, or a header-length decode that was off, would read back wrong bytes there. Extended frames are sent in basic mode, where a design that stored them, or pulsed for them, would show up through the pulse output and the read window. Release on an empty store and reset mode with entries held are both probed. A design that let the byte count underflow would raise the status flag falsely.

// File: rtl/canrx_pkg.sv
`timescale 1ns/1ps
package canrx_pkg;
  localparam int HDR_STD    = 3;
  localparam int HDR_EXT    = 5;
  localparam int MAX_DATA   = 8;
  localparam int ENT_SLOTS  = 16;   // power of two >= longest entry (13)

  typedef logic [ENT_SLOTS-1:0][7:0] entry_t;

  function automatic logic [3:0] data_cnt(input logic [3:0] dlc);
    return (dlc > 4'(MAX_DATA)) ? 4'(MAX_DATA) : dlc;
  endfunction

  function automatic logic [3:0] entry_len(input logic ext, input logic [3:0] dlc);
    return (ext ? 4'(HDR_EXT) : 4'(HDR_STD)) + data_cnt(dlc);
  endfunction
endpackage

// File: rtl/canrx_accept.sv
`timescale 1ns/1ps
module canrx_accept
  import canrx_pkg::*;
(
  input  logic        ext_mode_i,
  input  logic        frm_ext_i,
  input  logic [28:0] frm_id_i,
  input  logic [3:0]  frm_dlc_i,
  input  logic [63:0] frm_data_i,
  output logic        keep_o,
  output logic [3:0]  len_o,
  output entry_t      ent_o
);
  logic [3:0] hdr;
  logic [3:0] ndata;

  always_comb begin
    keep_o = ext_mode_i | ~frm_ext_i;
    hdr    = frm_ext_i ? 4'(HDR_EXT) : 4'(HDR_STD);
    ndata  = data_cnt(frm_dlc_i);
    len_o  = hdr + ndata;
    ent_o  = '0;
    ent_o[0] = {frm_ext_i, 3'b000, frm_dlc_i};
    if (frm_ext_i) begin
      ent_o[1] = frm_id_i[28:21];
      ent_o[2] = frm_id_i[20:13];
      ent_o[3] = frm_id_i[12:5];
      ent_o[4] = {frm_id_i[4:0], 3'b000};
    end else begin
      ent_o[1] = frm_id_i[10:3];
      ent_o[2] = {frm_id_i[2:0], 5'b00000};
    end
    for (int j = 0; j < MAX_DATA; j++) begin
      if (4'(j) < ndata) ent_o[hdr + 4'(j)] = frm_data_i[8*j +: 8];
    end
  end
endmodule

// File: rtl/canrx_byte_store.sv
`timescale 1ns/1ps
module canrx_byte_store
  import canrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wbase_i,
  input  logic [3:0]    wlen_i,
  input  entry_t        wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  input  logic [AW-1:0] haddr_i,
  output logic [7:0]    hdata_o
);
  logic [7:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [AW-1:0] off;
    logic          hit;
    logic [7:0]    cell_d;
    logic [7:0]    cell_q;

    always_comb begin
      off    = AW'(i) - wbase_i;
      hit    = we_i && (off < AW'(wlen_i));
      cell_d = hit ? wdata_i[off[3:0]] : cell_q;
    end

    always_ff @(posedge clk) cell_q <= cell_d;

    assign cells[i] = cell_q;
  end

  assign rdata_o = cells[raddr_i];
  assign hdata_o = cells[haddr_i];
endmodule

// File: rtl/canrx_ptr_ctrl.sv
`timescale 1ns/1ps
module canrx_ptr_ctrl
  import canrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_mode_i,
  input  logic          frm_valid_i,
  input  logic          keep_i,
  input  logic [3:0]    len_i,
  input  logic          release_i,
  input  logic          clr_ovr_i,
  input  logic [7:0]    head_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [AW:0]   used_o,
  output logic          ovr_o,
  output logic          irq_o
);
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]   used_q, used_d, free_b, wadd, rsub;
  logic          ovr_q, ovr_d, irq_q, irq_d;
  logic          cand, fits, rel;
  logic [3:0]    head_len;

  always_comb begin
    free_b   = (AW+1)'(DEPTH) - used_q;
    cand     = frm_valid_i && keep_i && !reset_mode_i;
    fits     = (AW+1)'(len_i) <= free_b;
    wr_en_o  = cand && fits;
    rel      = release_i && (used_q != '0) && !reset_mode_i;
    head_len = entry_len(head_i[7], head_i[3:0]);
    wadd     = wr_en_o ? (AW+1)'(len_i)    : '0;
    rsub     = rel     ? (AW+1)'(head_len) : '0;
    irq_d    = wr_en_o;
    if (reset_mode_i) begin
      wptr_d = '0;
      rptr_d = '0;
      used_d = '0;
      ovr_d  = 1'b0;
    end else begin
      wptr_d = wptr_q + wadd[AW-1:0];
      rptr_d = rptr_q + rsub[AW-1:0];
      used_d = used_q + wadd - rsub;
      if (cand && !fits)  ovr_d = 1'b1;
      else if (clr_ovr_i) ovr_d = 1'b0;
      else                ovr_d = ovr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      used_q <= '0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      used_q <= used_d;
      ovr_q  <= ovr_d;
      irq_q  <= irq_d;
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;
  assign used_o = used_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/canrx_msg_fifo.sv
`timescale 1ns/1ps
module canrx_msg_fifo
  import canrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reset_mode_i,
  input  logic        ext_mode_i,
  input  logic        frm_valid_i,
  input  logic        frm_ext_i,
  input  logic [28:0] frm_id_i,
  input  logic [3:0]  frm_dlc_i,
  input  logic [63:0] frm_data_i,
  input  logic [3:0]  rd_addr_i,
  output logic [7:0]  rd_data_o,
  input  logic        release_i,
  input  logic        clr_overrun_i,
  output logic        rbs_o,
  output logic        overrun_o,
  output logic        rx_irq_o
);
  logic          keep;
  logic [3:0]    ent_len;
  entry_t        ent;
  logic          wr_en;
  logic [AW-1:0] wptr, rptr, raddr;
  logic [AW:0]   used_cnt;
  logic [7:0]    head_byte;

  canrx_accept u_accept (
    .ext_mode_i (ext_mode_i),
    .frm_ext_i  (frm_ext_i),
    .frm_id_i   (frm_id_i),
    .frm_dlc_i  (frm_dlc_i),
    .frm_data_i (frm_data_i),
    .keep_o     (keep),
    .len_o      (ent_len),
    .ent_o      (ent)
  );

  canrx_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_mode_i (reset_mode_i),
    .frm_valid_i  (frm_valid_i),
    .keep_i       (keep),
    .len_i        (ent_len),
    .release_i    (release_i),
    .clr_ovr_i    (clr_overrun_i),
    .head_i       (head_byte),
    .wr_en_o      (wr_en),
    .wptr_o       (wptr),
    .rptr_o       (rptr),
    .used_o       (used_cnt),
    .ovr_o        (overrun_o),
    .irq_o        (rx_irq_o)
  );

  assign raddr = rptr + AW'(rd_addr_i);

  canrx_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .we_i    (wr_en),
    .wbase_i (wptr),
    .wlen_i  (ent_len),
    .wdata_i (ent),
    .raddr_i (raddr),
    .rdata_o (rd_data_o),
    .haddr_i (rptr),
    .hdata_o (head_byte)
  );

  assign rbs_o = (used_cnt != '0);
endmodule

// File: rtl/canrx_msg_fifo_chk.sv
`timescale 1ns/1ps
module canrx_msg_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reset_mode_i,
  input logic        ext_mode_i,
  input logic        frm_valid_i,
  input logic        frm_ext_i,
  input logic        release_i,
  input logic        clr_overrun_i,
  input logic [AW:0] used_cnt,
  input logic        rbs_o,
  input logic        overrun_o,
  input logic        rx_irq_o
);
  a_r2_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt <= (AW+1)'(DEPTH));

  a_r5_basic_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_i && !ext_mode_i && frm_ext_i |=> !rx_irq_o);

  a_r6_ovr_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> !rx_irq_o);

  a_r7_irq_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> rbs_o);

  a_r8_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
    release_i && !rbs_o && !frm_valid_i |=> !rbs_o && used_cnt == '0);

  a_r9_clear_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    clr_overrun_i && !frm_valid_i |=> !overrun_o);

  a_r10_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode_i |=> used_cnt == '0 && !overrun_o && !rbs_o && !rx_irq_o);
endmodule

bind canrx_msg_fifo canrx_msg_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reset_mode_i  (reset_mode_i),
  .ext_mode_i    (ext_mode_i),
  .frm_valid_i   (frm_valid_i),
  .frm_ext_i     (frm_ext_i),
  .release_i     (release_i),
  .clr_overrun_i (clr_overrun_i),
  .used_cnt      (used_cnt),
  .rbs_o         (rbs_o),
  .overrun_o     (overrun_o),
  .rx_irq_o      (rx_irq_o)
);

// File: tb/canrx_msg_fifo_tb_top.sv
`timescale 1ns/1ps
module canrx_msg_fifo_tb_top;
  localparam int CAP = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_mode_i = 1'b0, ext_mode_i = 1'b1;
  logic        frm_valid_i = 1'b0, frm_ext_i = 1'b0;
  logic [28:0] frm_id_i = '0;
  logic [3:0]  frm_dlc_i = '0;
  logic [63:0] frm_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic        release_i = 1'b0, clr_overrun_i = 1'b0;
  logic        rbs_o, overrun_o, rx_irq_o;

  always #5 clk = ~clk;

  canrx_msg_fifo dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mq[$];
  int         lq[$];

  typedef struct packed {
    logic mode; logic ext; logic [28:0] id; logic [3:0] dlc;
    logic [63:0] data; logic irq; logic ovr;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 1'b0, 29'h123,      4'd2,  64'h000000000000BBAA, 1'b1, 1'b0},
    '{1'b1, 1'b1, 29'h1ABCDEF1, 4'd8,  64'h0807060504030201, 1'b1, 1'b0},
    '{1'b0, 1'b1, 29'h00001234, 4'd4,  64'h00000000DEADBEEF, 1'b0, 1'b0},
    '{1'b0, 1'b0, 29'h7FF,      4'd0,  64'h0,                1'b1, 1'b0},
    '{1'b1, 1'b0, 29'h055,      4'd15, 64'h1122334455667788, 1'b1, 1'b0},
    '{1'b1, 1'b1, 29'h00000001, 4'd8,  64'hF0E0D0C0B0A09080, 1'b1, 1'b0},
    '{1'b1, 1'b1, 29'h1FFFFFFF, 4'd8,  64'h0F1E2D3C4B5A6978, 1'b1, 1'b0},
    '{1'b1, 1'b0, 29'h400,      4'd4,  64'h0000000099887766, 1'b0, 1'b1},
    '{1'b1, 1'b0, 29'h001,      4'd3,  64'h0000000000CAFE01, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference entry built from R1/R3; returns 1 if the model stores it.
  function automatic bit model_store(input logic ext, input logic [28:0] id,
                                     input logic [3:0] dlc, input logic [63:0] d);
    logic [7:0] b[$];
    int nd = (dlc > 8) ? 8 : int'(dlc);
    b.push_back({ext, 3'b000, dlc});
    if (ext) begin
      b.push_back(id[28:21]); b.push_back(id[20:13]);
      b.push_back(id[12:5]);  b.push_back({id[4:0], 3'b000});
    end else begin
      b.push_back(id[10:3]);  b.push_back({id[2:0], 5'b00000});
    end
    for (int j = 0; j < nd; j++) b.push_back(d[8*j +: 8]);
    if (b.size() > CAP - mq.size()) return 1'b0;
    foreach (b[k]) mq.push_back(b[k]);
    lq.push_back(b.size());
    return 1'b1;
  endfunction

  task automatic send(input logic mode, input logic ext, input logic [28:0] id,
                      input logic [3:0] dlc, input logic [63:0] d,
                      output logic irq, output logic ovr);
    @(negedge clk);
    ext_mode_i = mode; frm_ext_i = ext; frm_id_i = id;
    frm_dlc_i = dlc; frm_data_i = d; frm_valid_i = 1'b1;
    @(posedge clk); #1;
    irq = rx_irq_o; ovr = overrun_o;
    @(negedge clk);
    frm_valid_i = 1'b0;
    @(posedge clk); #1;
    chk(rx_irq_o == 1'b0, "R11", "receive pulse one cycle", rx_irq_o, 0);
  endtask

  task automatic check_head(input string req);
    for (int k = 0; k < lq[0]; k++) begin
      @(negedge clk);
      rd_addr_i = 4'(k);
      #2;
      chk(rd_data_o == mq[k], req, $sformatf("window byte %0d", k), rd_data_o, mq[k]);
    end
  endtask

  task automatic release_head();
    @(negedge clk); release_i = 1'b1;
    @(negedge clk); release_i = 1'b0;
    if (lq.size() != 0) begin
      for (int k = 0; k < lq[0]; k++) void'(mq.pop_front());
      void'(lq.pop_front());
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    logic irq, ovr;
    bit   st;
    repeat (3) @(posedge clk);
    #1;
    chk(rbs_o == 0 && overrun_o == 0 && rx_irq_o == 0, "R7", "reset state",
        {rbs_o, overrun_o, rx_irq_o}, 0);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: mixed modes, formats, lengths, fill to exactly 64 bytes
    for (int v = 0; v < 9; v++) begin
      st = (VEC[v].mode || !VEC[v].ext) ?
           model_store(VEC[v].ext, VEC[v].id, VEC[v].dlc, VEC[v].data) : 1'b0;
      send(VEC[v].mode, VEC[v].ext, VEC[v].id, VEC[v].dlc, VEC[v].data, irq, ovr);
      chk(irq == VEC[v].irq && irq == st, "R2 R4 R5 R11",
          $sformatf("vector %0d receive pulse", v), irq, VEC[v].irq);
      chk(ovr == VEC[v].ovr, "R6", $sformatf("vector %0d overrun", v), ovr, VEC[v].ovr);
    end
    chk(rbs_o == 1, "R7", "status with entries", rbs_o, 1);

    // R9: clear overrun, then overrun again on a full store
    @(negedge clk); clr_overrun_i = 1'b1;
    @(negedge clk); clr_overrun_i = 1'b0;
    chk(overrun_o == 0, "R9", "overrun cleared", overrun_o, 0);
    send(1'b1, 1'b0, 29'h3, 4'd0, 64'h0, irq, ovr);
    chk(irq == 0 && ovr == 1, "R6", "full store 3-byte frame", {irq, ovr}, 2'b01);

    // Drain: R1 R3 header/data layout, R6 entries intact, R8 release order
    while (lq.size() > 0) begin
      check_head("R1 R3 R6");
      release_head();
    end
    chk(rbs_o == 0, "R7", "status after drain", rbs_o, 0);

    // R8: release while empty has no effect
    release_head();
    chk(rbs_o == 0, "R8", "release on empty", rbs_o, 0);
    st = model_store(1'b0, 29'h2AA, 4'd1, 64'h5A);
    send(1'b1, 1'b0, 29'h2AA, 4'd1, 64'h5A, irq, ovr);
    chk(irq == 1, "R8", "frame after empty release", irq, 1);
    check_head("R8");
    release_head();

    // R12: wrap around the end of the array
    for (int f = 0; f < 4; f++) begin
      st = model_store(1'b1, 29'(32'h100 + f), 4'd8, {8{8'(8'h30 + f)}});
      send(1'b1, 1'b1, 29'(32'h100 + f), 4'd8, {8{8'(8'h30 + f)}}, irq, ovr);
    end
    release_head(); release_head();
    for (int f = 4; f < 6; f++) begin
      st = model_store(1'b1, 29'(32'h100 + f), 4'd8, {8{8'(8'h30 + f)}});
      send(1'b1, 1'b1, 29'(32'h100 + f), 4'd8, {8{8'(8'h30 + f)}}, irq, ovr);
      chk(irq == 1, "R12", "wrapping frame stored", irq, 1);
    end
    send(1'b1, 1'b1, 29'h1FF, 4'd8, 64'h0, irq, ovr);
    chk(irq == 0 && ovr == 1, "R2", "13 bytes into 12 free", {irq, ovr}, 2'b01);
    while (lq.size() > 0) begin
      check_head("R12");
      release_head();
    end

    // R10: reset mode empties the store and ignores frames
    st = model_store(1'b0, 29'h011, 4'd2, 64'h7766);
    send(1'b1, 1'b0, 29'h011, 4'd2, 64'h7766, irq, ovr);
    @(negedge clk); reset_mode_i = 1'b1;
    send(1'b1, 1'b0, 29'h022, 4'd1, 64'h44, irq, ovr);
    chk(irq == 0, "R10", "frame in reset mode", irq, 0);
    chk(rbs_o == 0 && overrun_o == 0, "R10", "store empty in reset mode",
        {rbs_o, overrun_o}, 0);
    @(negedge clk); reset_mode_i = 1'b0;
    mq.delete(); lq.delete();
    st = model_store(1'b1, 29'h0ABCDEF, 4'd3, 64'h332211);
    send(1'b1, 1'b1, 29'h0ABCDEF, 4'd3, 64'h332211, irq, ovr);
    chk(irq == 1 && rbs_o == 1, "R10", "store after reset mode", {irq, rbs_o}, 2'b11);
    check_head("R10");

    finish_run();
  end
endmodule